// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block holds the control words for a downstream PHY power-up sequencer and serves them over a simple memory-mapped bus. Seven 32-bit control words sit at consecutive word offsets. A read-only status word further up returns two live completion flags from the PHY.

Every write word carries its own per-bit write mask in its upper half. Software can therefore set or clear one field, such as the DLL enable, without first reading the word back. The bank decodes named fields out of two of the control words and drives them straight to the sequencer. It also forces any drive-strength code outside the legal set back to the default code.

Writes take effect on the clock edge that samples the write strobe. Read data is registered and appears on the cycle after the read strobe.

Top module: `ctlbank_top`

## Requirements
- R1: After reset, every control word reads as zero, every field output is zero, and the read data port is zero.
- R2: On a write to a control word, lower bit x (x from 0 to 15) takes bit x of the write word only when bit x+16 of that same word is 1. Otherwise bit x keeps its old value.
- R3: Control words 0 to 6 sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Reading one returns its 16 stored bits in bits 15:0 and zero in bits 31:16.
- R4: Read data is loaded on the clock edge that samples the read strobe. It is valid from that edge on and holds its value while the read strobe is low.
- R5: A read of offset 0x20 returns the status word. Bit 6 is the live calibration-done input, bit 5 is the live DLL-ready input, and every other bit is zero.
- R6: The following are unmapped offsets: any offset with bits 1:0 not zero, and any aligned offset other than 0x00 to 0x18 and 0x20. Writes to offset 0x20 or to an unmapped offset change no control word and no field output. Reads of an unmapped offset return zero.
- R7: Control word 6 drives three fields: bit 0 is the power-up enable, bit 1 is the DLL enable, and bits 6:4 are the stored drive-strength code.
- R8: Control word 0 drives three fields: bits 13:12 are the DLL frequency select, bit 11 is the output tap delay enable, and bits 10:7 are the output tap delay select.
- R9: The drive-strength output equals the stored code when that code is 0 to 4 (0 = 50 ohm, 1 = 33, 2 = 66, 3 = 100, 4 = 40). For stored codes 5, 6 and 7 it outputs 0, the 50 ohm code. Readback still returns the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 32 | Write word: mask in 31:16, data in 15:0 |
| busRdEn | input | 1 | Single-cycle read strobe |
| busRdData | output | 32 | Registered read data |
| calDone | input | 1 | Live calibration-done flag from the PHY |
| dllReady | input | 1 | Live DLL-ready flag from the PHY |
| pwrUp | output | 1 | Power-up enable (word 6 bit 0) |
| dllEnable | output | 1 | DLL enable (word 6 bit 1) |
| driveCode | output | 3 | Legalised drive-strength code |
| dllFreqSel | output | 2 | DLL frequency select (word 0 bits 13:12) |
| tapDlyEnable | output | 1 | Output tap delay enable (word 0 bit 11) |
| tapDlySel | output | 4 | Output tap delay select (word 0 bits 10:7) |

## Verification
The hardest case to reach from the ports is a write whose mask covers only some of the bits that differ from the stored value. A mismatch between the mask and the data is only visible when old contents, new data and mask disagree bit by bit. The stimulus therefore mixes fully random masks and data with directed single-bit masks against words already filled with ones. The illegal drive codes 5 to 7 are also reached only through a masked write that sets bits 6:4 of word 6. They are written directly, and again through random traffic, while the fields and the readback are compared after every write.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int CTRL_WORDS = 7;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int ADDR_W     = 8;
  localparam int IDX_W      = $clog2(CTRL_WORDS);
  localparam int WIDX_W     = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] STATUS_OFF = 8'h20;

  // status bit positions
  localparam int CAL_BIT = 6;
  localparam int DLL_BIT = 5;

  // field map: power word
  localparam int PWR_WORD   = 6;
  localparam int PWR_BIT    = 0;
  localparam int DLLEN_BIT  = 1;
  localparam int DRV_LSB    = 4;
  localparam int DRV_W      = 3;
  localparam logic [DRV_W-1:0] DRV_MAX     = 3'd4;
  localparam logic [DRV_W-1:0] DRV_DEFAULT = 3'd0;

  // field map: clocking word
  localparam int CLK_WORD   = 0;
  localparam int FREQ_LSB   = 12;
  localparam int FREQ_W     = 2;
  localparam int TAPEN_BIT  = 11;
  localparam int TAP_LSB    = 7;
  localparam int TAP_W      = 4;

  typedef struct packed {
    logic [CTRL_WORDS-1:0] wrHit;
    logic                  rdGo;
    logic                  rdCtrl;
    logic                  rdStatus;
    logic [IDX_W-1:0]      rdIdx;
  } bankStrobes_t;

  function automatic logic [DRV_W-1:0] legalDrive(input logic [DRV_W-1:0] code);
    return (code > DRV_MAX) ? DRV_DEFAULT : code;
  endfunction
endpackage

// File: rtl/ctlbank_ctrl.sv
module ctlbank_ctrl
  import ctlbank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output bankStrobes_t      strobes
);
  localparam logic [WIDX_W-1:0] NUM_IDX = WIDX_W'(CTRL_WORDS);

  logic [WIDX_W-1:0]     wordIdx;
  logic                  aligned;
  logic                  ctrlHit;
  logic                  statusHit;
  logic [CTRL_WORDS-1:0] wrHitVec;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign aligned   = (busAddr[1:0] == 2'b00);
  assign ctrlHit   = aligned && (wordIdx < NUM_IDX);
  assign statusHit = (busAddr == STATUS_OFF);

  for (genvar g = 0; g < CTRL_WORDS; g++) begin : gHit
    assign wrHitVec[g] = busWrEn && ctrlHit && (wordIdx == WIDX_W'(g));
  end

  always_comb begin
    strobes          = '0;
    strobes.wrHit    = wrHitVec;
    strobes.rdGo     = busRdEn;
    strobes.rdCtrl   = ctrlHit;
    strobes.rdStatus = statusHit;
    strobes.rdIdx    = wordIdx[IDX_W-1:0];
  end
endmodule

// File: rtl/ctlbank_dp.sv
module ctlbank_dp
  import ctlbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobes_t       strobes,
  input  logic [DATA_W-1:0]  wrWord,
  input  logic               calDone,
  input  logic               dllReady,
  output logic [DATA_W-1:0]  rdData,
  output logic               pwrUp,
  output logic               dllEnable,
  output logic [DRV_W-1:0]   driveCode,
  output logic [FREQ_W-1:0]  dllFreqSel,
  output logic               tapDlyEnable,
  output logic [TAP_W-1:0]   tapDlySel
);
  logic [CTRL_WORDS-1:0][HALF_W-1:0] ctrlWord;
  logic [HALF_W-1:0] wrMask;
  logic [HALF_W-1:0] wrVal;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdNext;

  assign wrMask = wrWord[DATA_W-1:HALF_W];
  assign wrVal  = wrWord[HALF_W-1:0];

  for (genvar g = 0; g < CTRL_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlWord[g] <= '0;
      else if (strobes.wrHit[g])
        ctrlWord[g] <= (ctrlWord[g] & ~wrMask) | (wrVal & wrMask);
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[CAL_BIT] = calDone;
    statusWord[DLL_BIT] = dllReady;
  end

  always_comb begin
    if (strobes.rdCtrl)
      rdNext = {{HALF_W{1'b0}}, ctrlWord[strobes.rdIdx]};
    else if (strobes.rdStatus)
      rdNext = statusWord;
    else
      rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strobes.rdGo)
      rdData <= rdNext;
  end

  assign pwrUp        = ctrlWord[PWR_WORD][PWR_BIT];
  assign dllEnable    = ctrlWord[PWR_WORD][DLLEN_BIT];
  assign driveCode    = legalDrive(ctrlWord[PWR_WORD][DRV_LSB +: DRV_W]);
  assign dllFreqSel   = ctrlWord[CLK_WORD][FREQ_LSB +: FREQ_W];
  assign tapDlyEnable = ctrlWord[CLK_WORD][TAPEN_BIT];
  assign tapDlySel    = ctrlWord[CLK_WORD][TAP_LSB +: TAP_W];
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
  import ctlbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic              calDone,
  input  logic              dllReady,
  output logic              pwrUp,
  output logic              dllEnable,
  output logic [2:0]        driveCode,
  output logic [1:0]        dllFreqSel,
  output logic              tapDlyEnable,
  output logic [3:0]        tapDlySel
);
  bankStrobes_t strobes;

  ctlbank_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  ctlbank_dp uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrWord       (busWrData),
    .calDone      (calDone),
    .dllReady     (dllReady),
    .rdData       (busRdData),
    .pwrUp        (pwrUp),
    .dllEnable    (dllEnable),
    .driveCode    (driveCode),
    .dllFreqSel   (dllFreqSel),
    .tapDlyEnable (tapDlyEnable),
    .tapDlySel    (tapDlySel)
  );
endmodule

// File: rtl/ctlbank_chk.sv
module ctlbank_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        calDone,
  input logic        dllReady,
  input logic        pwrUp,
  input logic        dllEnable,
  input logic [2:0]  driveCode,
  input logic [1:0]  dllFreqSel,
  input logic        tapDlyEnable,
  input logic [3:0]  tapDlySel
);
  logic [12:0] fieldsNow;
  assign fieldsNow = {pwrUp, dllEnable, driveCode, dllFreqSel, tapDlyEnable, tapDlySel};

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[31:16] == 16'h0000); // R3

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData)); // R4

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 8'h20) |=>
      busRdData == {25'd0, $past(calDone), $past(dllReady), 5'd0}); // R5

  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == 8'h20 || busAddr[1:0] != 2'b00)) |=> $stable(fieldsNow)); // R6

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h18 && !busWrData[16]) |=> $stable(pwrUp)); // R2

  AST_PWR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h18 && busWrData[16]) |=> pwrUp == $past(busWrData[0])); // R7

  AST_FREQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h00 && busWrData[29:28] == 2'b11) |=>
      dllFreqSel == $past(busWrData[13:12])); // R8

  AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    driveCode <= 3'd4); // R9
endmodule

bind ctlbank_top ctlbank_chk uChk (.*);

// File: tb/tb_ctlbank_top.sv
module tb_ctlbank_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        calDone = 1'b0;
  logic        dllReady = 1'b0;
  logic        pwrUp, dllEnable, tapDlyEnable;
  logic [2:0]  driveCode;
  logic [1:0]  dllFreqSel;
  logic [3:0]  tapDlySel;

  int total = 0;
  int bad = 0;
  logic [15:0] model [7];

  always #4 clk = ~clk;

  ctlbank_top dut (.*);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic isCtrl(input logic [7:0] a);
    return (a[1:0] == 2'b00) && (a[7:2] < 6'd7);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (isCtrl(a)) return {16'h0, model[a[4:2]]};
    if (a == 8'h20) return {25'd0, calDone, dllReady, 5'd0};
    return 32'h0;
  endfunction

  function automatic logic [2:0] expDrive(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (isCtrl(a))
      model[a[4:2]] = (model[a[4:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic doRead(input logic [7:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    exp = expRead(a);
    @(negedge clk);
    busRdEn = 1'b0;
    check(busRdData == exp, req, busRdData, exp);
  endtask

  task automatic checkFields(input string req);
    logic [12:0] act, exp;
    act = {pwrUp, dllEnable, driveCode, dllFreqSel, tapDlyEnable, tapDlySel};
    exp = {model[6][0], model[6][1], expDrive(model[6][6:4]),
           model[0][13:12], model[0][11], model[0][10:7]};
    check(act == exp, req, {19'd0, act}, {19'd0, exp});
  endtask

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 16'h0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    checkFields("R1 fields after reset");
    check(busRdData == 32'h0, "R1 read port after reset", busRdData, 32'h0);
    rstN = 1'b1;
    for (int i = 0; i < 7; i++) doRead(8'(i * 4), "R1 word after reset");

    // R2 masked writes
    doWrite(8'h08, 32'hFFFF_FFFF);
    doWrite(8'h08, 32'h0010_0000);
    doRead(8'h08, "R2 single-bit clear");
    doWrite(8'h08, 32'h0000_0000);
    doRead(8'h08, "R2 empty mask keeps word");
    doWrite(8'h08, 32'hF0F0_1234);
    doRead(8'h08, "R2 partial mask");
    // R3 upper half ignored on readback
    doWrite(8'h14, 32'hFFFF_ABCD);
    doRead(8'h14, "R3 upper half reads zero");
    doWrite(8'h04, 32'h00FF_5A5A);
    doRead(8'h04, "R3 word 1 offset");

    // R7 power word fields
    doWrite(8'h18, 32'h0001_0001);
    checkFields("R7 power-up enable");
    doWrite(8'h18, 32'h0002_0002);
    checkFields("R7 DLL enable");
    doWrite(8'h18, 32'h0001_0000);
    checkFields("R7 power-up clear keeps DLL");
    // R8 clock word fields
    doWrite(8'h00, 32'h3FFF_2A80);
    checkFields("R8 freq/tap fields");
    doWrite(8'h00, 32'h3000_1000);
    checkFields("R8 freq select only");
    // R9 drive codes
    for (int c = 0; c < 8; c++) begin
      doWrite(8'h18, 32'h0070_0000 | 32'(c << 4));
      checkFields("R9 drive code legalised");
      doRead(8'h18, "R9 stored code readback");
    end

    // R5 status
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      calDone = s[1]; dllReady = s[0];
      doRead(8'h20, "R5 status word");
    end

    // R6 ignored writes and unmapped reads
    doWrite(8'h20, 32'hFFFF_FFFF);
    doWrite(8'h1C, 32'hFFFF_FFFF);
    doWrite(8'h19, 32'hFFFF_0000);
    doWrite(8'h02, 32'hFFFF_FFFF);
    checkFields("R6 ignored writes leave fields");
    for (int i = 0; i < 7; i++) doRead(8'(i * 4), "R6 words unchanged");
    doRead(8'h1C, "R6 unmapped read zero");
    doRead(8'h24, "R6 unmapped read zero");
    doRead(8'h01, "R6 unaligned read zero");

    // R4 hold while read strobe low
    doRead(8'h04, "R4 read latency");
    @(negedge clk);
    busAddr = 8'h00;
    @(negedge clk);
    check(busRdData == {16'h0, model[1]}, "R4 hold without strobe", busRdData, {16'h0, model[1]});

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int r;
      r = $urandom_range(0, 11);
      if (r < 8) a = 8'(r * 4);
      else if (r == 8) a = 8'h20;
      else if (r == 9) a = 8'h24;
      else if (r == 10) a = 8'($urandom_range(0, 7) * 4 + $urandom_range(1, 3));
      else a = 8'hFC;
      calDone = 1'($urandom());
      dllReady = 1'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        doWrite(a, $urandom());
        checkFields("R2 random masked write fields");
      end else begin
        doRead(a, "R3 random readback");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule